// File: doc/BRIEF.md
# Serial Link Input-Frame Builder

This block builds the codec-to-controller half of a 256-bit time-slotted audio link and sends it out one bit per bit-clock cycle. Each frame opens with a 16-bit tag slot, followed by twelve 20-bit slots. The block fills four of them. The tag slot carries a ready flag and the valid marks. Slot 1 carries the echoed register index and the two sample-request flags. Slot 2 carries the register contents being returned. Slot 3 carries the left record sample. All later slots are sent as zeros.

A read command taken from the controller's output frame is held in the block until the next frame begins. That frame answers it once, with the index looped back and the register file's contents beside it. The index is echoed even when no register exists at that address. Frames after that one carry invalid status slots until another read arrives. The request flags are sent in every frame, whether or not a reply is in progress. The frame sync is sampled on the bit clock, and output bits are launched on rising edges so that the far end can capture them on falling edges.

Top module: `aclink_in_serializer`

## Requirements
- R1: Out of reset `sdata_out` is 0, and it stays 0 until a frame starts.
- R2: If rising edge k is the first that samples `sync_in` high after a low sample, then after edge k+1 `sdata_out` shows frame bit 255. After each later edge it shows the next lower bit, down to bit 0. After that it shows 0 until the next frame.
- R3: Frame bits 255..240 form the tag slot. Bit 255 is `codec_ready`. Bits 254 and 253 are 1 exactly when the frame carries a read reply. Bit 252 is the inverse of `adc_pd`. Bits 251..240 are 0.
- R4: Slot 1 occupies frame bits 239..220. Its bit 19 (frame 239) is always 0. Its bits 18..12 (frame 238..232) are all 0 in a frame without a read reply.
- R5: In a reply frame, slot 1 bits 18..12 return the 7-bit index of the read command, for any index value. `reg_index` presents that index to the register file from the clock edge after the command.
- R6: A read command (`cmd_valid` and `cmd_read` high on the same edge) is answered only in the next frame that starts after it. Later frames carry no reply unless another read arrives. If several reads arrive before a frame starts, the last one is answered.
- R7: Slot 2 occupies frame bits 219..200. In a reply frame, slot 2 bits 19..4 carry `reg_rdata`, sampled at the load edge. Bits 3..0 are 0. The whole slot is 0 in frames without a reply.
- R8: In every frame, slot 1 bit 11 (frame 231) equals `slot_req[0]`, the slot 3 request, and slot 1 bit 10 (frame 230) equals `slot_req[1]`, the slot 4 request (0 = send data). Slot 1 bits 9..0 are 0.
- R9: Slot 3 occupies frame bits 199..180. With `adc_pd` low, slot 3 bits 19..2 carry `adc_sample`, MSB first, and bits 1..0 are 0.
- R10: With `adc_pd` high at the load edge, the slot 3 valid tag (frame bit 252) is 0 and all of slot 3 is 0.
- R11: Frame bits 179..0 (slots 4 to 12) are 0.
- R12: A command with `cmd_read` low creates no reply. The next frame shows zero tags for slots 1 and 2 and zero status slots.
- R13: Holding `sync_in` high for more than one cycle starts only one frame. A new frame needs a new low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Link bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Frame sync from the controller |
| codec_ready | input | 1 | Ready flag placed in tag bit 15 |
| cmd_valid | input | 1 | One-cycle strobe: a command was decoded from the output frame |
| cmd_read | input | 1 | The decoded command is a read |
| cmd_index | input | 7 | Register index of the decoded command |
| reg_index | output | 7 | Index presented to the register file read port |
| reg_rdata | input | 16 | Register file read data for `reg_index` |
| adc_sample | input | 18 | Left record sample, two's complement |
| adc_pd | input | 1 | Converter powered down |
| slot_req | input | 2 | Sample-request flags for slots 3 and 4, 0 = request |
| sdata_out | output | 1 | Serial input-frame data |

## Verification
On every cycle, the assertions check that the first bit after a load is the ready flag. They check that a pending read is cleared when a frame loads, unless a new read arrives on that same edge. They check that the tag and reserved fields of the assembled frame follow the power-down flag, the request flags and the reply state. Only the bench scenarios can show the full serial stream: the position of each bit, the one-shot lifetime of a reply over several frames, the last-read-wins case, ignored non-read commands, and a long sync pulse starting only one frame. The bench does this by comparing every output bit against a behavioural frame model.

// File: rtl/aclink_in_pkg.sv
// Frame geometry shared by the input-frame serializer, its helpers and its checker.
// Assumes one 16-bit tag slot followed by twelve 20-bit slots.
package aclink_in_pkg;
    localparam int SLOT0_W   = 16;
    localparam int SLOT_W    = 20;
    localparam int NUM_SLOTS = 13;
    localparam int FRAME_W   = SLOT0_W + (NUM_SLOTS - 1) * SLOT_W;

    // Least significant frame bit of each filled slot
    localparam int S0_LSB = FRAME_W - SLOT0_W;
    localparam int S1_LSB = S0_LSB - SLOT_W;
    localparam int S2_LSB = S1_LSB - SLOT_W;
    localparam int S3_LSB = S2_LSB - SLOT_W;

    // Bit positions inside the tag slot
    localparam int TAG_READY = 15;
    localparam int TAG_S1    = 14;
    localparam int TAG_S2    = 13;
    localparam int TAG_S3    = 12;

    // Field positions inside slots 1 and 2
    localparam int IDX_LSB   = 12;
    localparam int REQ_TOP   = 11;
    localparam int RDATA_LSB = 4;
endpackage

// File: rtl/aclink_in_sync_detect.sv
// Frame-start detector.
// Samples the frame sync on the bit clock and raises frame_load for exactly one
// cycle after the first high sample that follows a low one.
// Assumes sync_in is already synchronous to bit_clk.
module aclink_in_sync_detect (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic frame_load
);
    logic sync_q;

    // Remember the previous sync sample and flag a low-to-high transition
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            sync_q     <= 1'b0;
            frame_load <= 1'b0;
        end else begin
            sync_q     <= sync_in;
            frame_load <= sync_in & ~sync_q;
        end
    end
endmodule

// File: rtl/aclink_in_read_track.sv
// Read-reply tracker.
// Holds the most recent read command until a frame loads, so that the reply is
// sent once. A command arriving on the load edge survives the clear and is kept
// for the following frame. Non-read commands are ignored.
module aclink_in_read_track #(
    parameter int IDX_W = 7
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_read,
    input  logic [IDX_W-1:0] cmd_index,
    input  logic             frame_load,
    output logic             resp_pending,
    output logic [IDX_W-1:0] resp_index
);
    logic take_read;

    // A command counts only when it is a read
    always_comb take_read = cmd_valid & cmd_read;

    // Set on a read, clear on frame load; a new read wins over the clear
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            resp_pending <= 1'b0;
            resp_index   <= '0;
        end else begin
            if (take_read) begin
                resp_pending <= 1'b1;
                resp_index   <= cmd_index;
            end else if (frame_load) begin
                resp_pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/aclink_in_frame_build.sv
// Frame assembler.
// Combinationally forms the full input frame from the present inputs. Slots
// past 3 and every reserved field are zero. Assumes IDX_W <= 7, DATA_W <= 16,
// ADC_W <= 18 and REQ_W <= 2, so each field fits its slot.
module aclink_in_frame_build
    import aclink_in_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16,
    parameter int ADC_W  = 18,
    parameter int REQ_W  = 2
) (
    input  logic               codec_ready,
    input  logic               resp_valid,
    input  logic [IDX_W-1:0]   resp_index,
    input  logic [DATA_W-1:0]  reg_rdata,
    input  logic [ADC_W-1:0]   adc_sample,
    input  logic               adc_pd,
    input  logic [REQ_W-1:0]   slot_req,
    output logic [FRAME_W-1:0] frame
);
    localparam int ADC_LSB = S3_LSB + SLOT_W - ADC_W;

    logic [FRAME_W-1:0] reqs;

    // Place each request flag one bit below the previous, starting at slot 1 bit 11
    generate
        for (genvar gi = 0; gi < FRAME_W; gi++) begin : g_req
            if (gi <= S1_LSB + REQ_TOP && gi > S1_LSB + REQ_TOP - REQ_W) begin : g_on
                assign reqs[gi] = slot_req[S1_LSB + REQ_TOP - gi];
            end else begin : g_off
                assign reqs[gi] = 1'b0;
            end
        end
    endgenerate

    // Assemble tags, status slots and record slot
    always_comb begin
        frame = reqs;
        frame[S0_LSB + TAG_READY] = codec_ready;
        frame[S0_LSB + TAG_S1]    = resp_valid;
        frame[S0_LSB + TAG_S2]    = resp_valid;
        frame[S0_LSB + TAG_S3]    = ~adc_pd;
        if (resp_valid) begin
            frame[S1_LSB + IDX_LSB +: IDX_W]    = resp_index;
            frame[S2_LSB + RDATA_LSB +: DATA_W] = reg_rdata;
        end
        if (!adc_pd) begin
            frame[ADC_LSB +: ADC_W] = adc_sample;
        end
    end
endmodule

// File: rtl/aclink_in_serializer.sv
// Input-frame serializer (top).
// On the cycle after a frame start is detected, loads the assembled frame into
// a shift register and then launches one bit per rising bit-clock edge, MSB
// first. The read-reply state is cleared by that same load. Assumes reg_rdata
// is a combinational read of reg_index.
module aclink_in_serializer
    import aclink_in_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16,
    parameter int ADC_W  = 18,
    parameter int REQ_W  = 2
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic              codec_ready,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [IDX_W-1:0]  cmd_index,
    output logic [IDX_W-1:0]  reg_index,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [ADC_W-1:0]  adc_sample,
    input  logic              adc_pd,
    input  logic [REQ_W-1:0]  slot_req,
    output logic              sdata_out
);
    logic               frame_load;
    logic               resp_pending;
    logic [IDX_W-1:0]   resp_index;
    logic [FRAME_W-1:0] frame_word;
    logic [FRAME_W-1:0] shreg;

    aclink_in_sync_detect u_sync (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .frame_load (frame_load)
    );

    aclink_in_read_track #(.IDX_W(IDX_W)) u_track (
        .bit_clk      (bit_clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_read     (cmd_read),
        .cmd_index    (cmd_index),
        .frame_load   (frame_load),
        .resp_pending (resp_pending),
        .resp_index   (resp_index)
    );

    aclink_in_frame_build #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .ADC_W  (ADC_W),
        .REQ_W  (REQ_W)
    ) u_build (
        .codec_ready (codec_ready),
        .resp_valid  (resp_pending),
        .resp_index  (resp_index),
        .reg_rdata   (reg_rdata),
        .adc_sample  (adc_sample),
        .adc_pd      (adc_pd),
        .slot_req    (slot_req),
        .frame       (frame_word)
    );

    // The register file always sees the index of the reply being prepared
    always_comb reg_index = resp_index;

    // Load the frame on start, otherwise shift left filling with zeros
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (frame_load) begin
            shreg <= frame_word;
        end else begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
    end

    // Serial output is the top of the shift register
    always_comb sdata_out = shreg[FRAME_W-1];
endmodule

// File: rtl/aclink_in_checker.sv
// Property checker for the input-frame serializer, attached by bind.
// Observes the load strobe, the reply state, the serial output and the
// assembled tag, slot 1 and slot 3 fields.
module aclink_in_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        load,
    input logic        sdata,
    input logic        codec_ready,
    input logic        adc_pd,
    input logic [1:0]  slot_req,
    input logic        cmd_valid,
    input logic        cmd_read,
    input logic        pending,
    input logic [15:0] tag_slot,
    input logic [19:0] stat_addr,
    input logic [19:0] rec_slot
);
    // R2: the first launched bit is the ready flag seen at the load edge
    a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sdata == $past(codec_ready)));

    // R6: a load ends the reply unless a new read arrived on that edge
    a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!pending || $past(cmd_valid && cmd_read)));

    // R3: ready tag follows the port, reserved tag bits stay clear
    a_r3_tag_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_slot[15] == codec_ready) && (tag_slot[11:0] == 12'h000)
        && (tag_slot[14] == tag_slot[13]));

    // R4: no index in slot 1 without its valid tag, bit 19 always clear
    a_r4_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!tag_slot[14] |-> (stat_addr[18:12] == 7'h00)) && !stat_addr[19]);

    // R8: request flags mirror the inputs, lower bits stay clear
    a_r8_request_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_addr[11] == slot_req[0]) && (stat_addr[10] == slot_req[1])
        && (stat_addr[9:0] == 10'h000));

    // R10: power-down clears the slot 3 tag and the slot 3 data
    a_r10_pd_blank: assert property (@(posedge clk) disable iff (!rst_n)
        adc_pd |-> (!tag_slot[12] && (rec_slot == 20'h00000)));

    // R9: the two low bits of slot 3 are always clear
    a_r9_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        rec_slot[1:0] == 2'b00);
endmodule

bind aclink_in_serializer aclink_in_checker u_chk (
    .clk         (bit_clk),
    .rst_n       (rst_n),
    .load        (frame_load),
    .sdata       (sdata_out),
    .codec_ready (codec_ready),
    .adc_pd      (adc_pd),
    .slot_req    (slot_req),
    .cmd_valid   (cmd_valid),
    .cmd_read    (cmd_read),
    .pending     (resp_pending),
    .tag_slot    (frame_word[aclink_in_pkg::S0_LSB +: 16]),
    .stat_addr   (frame_word[aclink_in_pkg::S1_LSB +: 20]),
    .rec_slot    (frame_word[aclink_in_pkg::S3_LSB +: 20])
);

// File: tb/tb_aclink_in_serializer.sv
module tb_aclink_in_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_in = 1'b0;
    logic        codec_ready = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [6:0]  cmd_index = 7'h00;
    logic [6:0]  reg_index;
    logic [15:0] reg_rdata;
    logic [17:0] adc_sample = 18'h00000;
    logic        adc_pd = 1'b0;
    logic [1:0]  slot_req = 2'b11;
    logic        sdata_out;

    int errors = 0;
    int checks = 0;
    string scen = "R1";

    always #2 clk = ~clk;

    aclink_in_serializer dut (
        .bit_clk     (clk),
        .rst_n       (rst_n),
        .sync_in     (sync_in),
        .codec_ready (codec_ready),
        .cmd_valid   (cmd_valid),
        .cmd_read    (cmd_read),
        .cmd_index   (cmd_index),
        .reg_index   (reg_index),
        .reg_rdata   (reg_rdata),
        .adc_sample  (adc_sample),
        .adc_pd      (adc_pd),
        .slot_req    (slot_req),
        .sdata_out   (sdata_out)
    );

    // Behavioural register file
    function automatic logic [15:0] rfile(input logic [6:0] a);
        return {a, 9'h000} ^ 16'hA5C3;
    endfunction
    assign reg_rdata = rfile(reg_index);

    // Requirement that owns a given frame bit position
    function automatic string tag_for(input int p);
        if (p < 0)    return "R1/R2";
        if (p == 255) return "R2";
        if (p >= 240) return "R3";
        if (p == 239) return "R4";
        if (p >= 232) return "R6";
        if (p >= 220) return "R8";
        if (p >= 200) return "R7";
        if (p >= 180) return "R9";
        return "R11";
    endfunction

    // Reference model: queue of expected bits
    bit         q[$];
    bit         m_pend = 1'b0;
    bit         m_start = 1'b0;
    bit         m_sprev = 1'b0;
    logic [6:0] m_idx = 7'h00;
    bit         exp_bit = 1'b0;
    int         pos = -1;
    bit         started = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_pend = 1'b0; m_start = 1'b0; m_sprev = 1'b0;
            exp_bit = 1'b0; pos = -1;
        end else begin
            if (m_start) begin
                logic [255:0] fr;
                fr = '0;
                fr[255] = codec_ready;
                fr[254] = m_pend;
                fr[253] = m_pend;
                fr[252] = !adc_pd;
                if (m_pend) begin
                    fr[238:232] = m_idx;
                    fr[219:204] = rfile(m_idx);
                end
                fr[231] = slot_req[0];
                fr[230] = slot_req[1];
                if (!adc_pd) fr[199:182] = adc_sample;
                q.delete();
                for (int b = 255; b >= 0; b--) q.push_back(fr[b]);
                pos = 256;
                m_pend = 1'b0;
            end
            if (q.size() > 0) begin
                exp_bit = q.pop_front();
                pos = pos - 1;
            end else begin
                exp_bit = 1'b0;
                pos = -1;
            end
            if (cmd_valid && cmd_read) begin
                m_pend = 1'b1;
                m_idx = cmd_index;
            end
            m_start = sync_in && !m_sprev;
            m_sprev = sync_in;
        end
        started = 1'b1;
    end

    // Compare every output bit away from the active edge
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (sdata_out !== exp_bit) begin
                errors++;
                $display("FAIL %s (%s) bit=%0d actual=%b expected=%b",
                         tag_for(pos), scen, pos, sdata_out, exp_bit);
            end
        end
    end

    // One 256-cycle frame with up to two commands at chosen cycles
    task automatic run_frame(input int c1, input bit r1, input logic [6:0] i1,
                             input int c2, input bit r2, input logic [6:0] i2);
        for (int i = 0; i < 256; i++) begin
            sync_in   = (i < 16);
            cmd_valid = (i == c1) || (i == c2);
            cmd_read  = (i == c1) ? r1 : r2;
            cmd_index = (i == c1) ? i1 : i2;
            @(negedge clk);
            if (i == c1 + 1 && r1 && c2 < 0) begin
                checks++;
                if (reg_index !== i1) begin
                    errors++;
                    $display("FAIL R5 reg_index actual=%h expected=%h", reg_index, i1);
                end
            end
        end
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        codec_ready = 1'b1;
        adc_sample  = 18'h2AAAA;
        slot_req    = 2'b10;
        scen = "R8";  run_frame(-1, 0, 0, -1, 0, 0);
        scen = "R6";  run_frame(40, 1, 7'h05, -1, 0, 0);
        adc_sample = 18'h1F00F;
        run_frame(-1, 0, 0, -1, 0, 0);
        run_frame(-1, 0, 0, -1, 0, 0);
        scen = "R5";  run_frame(100, 1, 7'h7F, -1, 0, 0);
        slot_req = 2'b01;
        run_frame(-1, 0, 0, -1, 0, 0);
        scen = "R12"; run_frame(50, 0, 7'h12, -1, 0, 0);
        run_frame(-1, 0, 0, -1, 0, 0);
        scen = "R6";  run_frame(30, 1, 7'h11, 60, 1, 7'h22);
        codec_ready = 1'b0;
        adc_sample  = 18'h20001;
        run_frame(-1, 0, 0, -1, 0, 0);
        scen = "R10"; adc_pd = 1'b1; slot_req = 2'b00;
        run_frame(20, 1, 7'h33, -1, 0, 0);
        run_frame(-1, 0, 0, -1, 0, 0);
        adc_pd = 1'b0;
        scen = "R13";
        sync_in = 1'b1;
        repeat (300) @(negedge clk);
        sync_in = 1'b0;
        repeat (40) @(negedge clk);
        scen = "R2";  run_frame(-1, 0, 0, -1, 0, 0);
        repeat (20) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule